// File: doc/BRIEF.md
# MAC Perfect Address Filter

This block screens received Ethernet frames against two programmable 48-bit station addresses. The frame arrives as a byte stream with a valid strobe, a start-of-frame flag on the first byte and an end-of-frame flag on the last byte. The block captures the first twelve bytes, the destination address followed by the source address. In the cycle after the twelfth byte it issues a one-cycle verdict: a hit flag for each entry and a combined pass flag.

The primary entry is always compared with the destination address. The secondary entry can be switched off. It can be pointed at either the destination or the source field, and any of its six bytes can be left out of the comparison. Configuration is loaded through a small write port. Each frame compares against a copy of the configuration taken at its first byte, so a write made during a frame never changes that frame's verdict.

Top module: `mac_addr_filter`

## Requirements
- R1: After reset the primary address and the secondary address are both all ones (48'hFFFF_FFFF_FFFF). The secondary entry is disabled, compares the destination field and has a zero mask.
- R2: A write with `cfg_sel`=0 loads primary bits 31:0. `cfg_sel`=1 loads primary bits 47:32 from `cfg_wdata[15:0]`, and the upper write bits are ignored. `cfg_sel`=2 loads secondary bits 31:0. `cfg_sel`=3 loads secondary bits 47:32 from bits 15:0, the enable from bit 31, the source-select from bit 30 and the byte mask from bits 29:24.
- R3: Frame byte k (k = 0..5, first byte k=0) is compared with address bits 8k+7:8k of the destination. Frame byte 6+k is compared with the same bits of the source.
- R4: `res_valid` is high for exactly one cycle, the cycle after the clock edge that accepts the 12th byte. Bytes after the 12th give no further result until the next start of frame.
- R5: `res_pri_hit` is set when all 48 destination bits equal the primary address.
- R6: When the secondary enable is clear, `res_sec_hit` stays low.
- R7: With the secondary enabled, source-select set makes the entry compare the source field. Source-select clear makes it compare the destination field.
- R8: Mask bit 24+k set removes address byte k (bits 8k+7:8k) from the secondary comparison.
- R9: `res_pass` equals `res_pri_hit` OR `res_sec_hit` on every result.
- R10: A frame whose end flag arrives with fewer than 12 bytes gives one result strobe with all flags low. A frame ending on its 12th byte gives a single strobe.
- R11: A write affects comparison only from the next start of frame. This includes a write in the same cycle as the start-of-frame byte.
- R12: While `res_valid` is low, all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Selects the configuration word written |
| cfg_wdata | input | 32 | Configuration write data |
| rx_valid | input | 1 | Received byte valid |
| rx_sof | input | 1 | First byte of frame (with rx_valid) |
| rx_eof | input | 1 | Last byte of frame (with rx_valid) |
| rx_data | input | 8 | Received byte |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_pri_hit | output | 1 | Primary entry matched |
| res_sec_hit | output | 1 | Secondary entry matched |
| res_pass | output | 1 | Frame accepted by either entry |

## Verification
The bench targets byte order: a destination that is the primary address byte-reversed must miss, so a design that fed the first byte into the top address byte would hit there. It checks the end and start masks separately, so an off-by-one mask mapping fails one of them. It pairs source-select with frames where only the other field matches, to catch a select that is inverted or ignored. It writes configuration mid-frame and on the start-of-frame byte itself; a design that compared against live registers would change that frame's verdict. It also sends short frames, which must still strobe without passing, and long frames, which must strobe once at the right cycle.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int HDR_BYTES  = 2 * ADDR_BYTES;
  localparam int CNT_W      = $clog2(HDR_BYTES + 1);
  localparam int REG_W      = 32;
  localparam int HI_W       = ADDR_W - REG_W;
  localparam int EN_BIT     = 31;
  localparam int SRC_BIT    = 30;
  localparam int MASK_LSB   = 24;

  typedef enum logic [1:0] {
    SEL_PRI_LO = 2'd0,
    SEL_PRI_HI = 2'd1,
    SEL_SEC_LO = 2'd2,
    SEL_SEC_HI = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [ADDR_W-1:0]     pri;
    logic [ADDR_W-1:0]     sec;
    logic                  sec_en;
    logic                  sec_src;
    logic [ADDR_BYTES-1:0] sec_mask;
  } filt_cfg_t;

  localparam logic [ADDR_W-1:0] ADDR_RST = '1;

  // Byte-wise equality with per-byte exclusion; bit k of skip covers byte k.
  function automatic logic addr_hit(input logic [ADDR_W-1:0] station,
                                    input logic [ADDR_W-1:0] field,
                                    input logic [ADDR_BYTES-1:0] skip);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (!skip[k] && station[k*BYTE_W +: BYTE_W] != field[k*BYTE_W +: BYTE_W])
        ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/mpf_cfg_regs.sv
module mpf_cfg_regs
  import mpf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             snap_load,
  output filt_cfg_t        snap
);
  logic [ADDR_W-1:0]     pri_q, sec_q;
  logic                  en_q, src_q;
  logic [ADDR_BYTES-1:0] mask_q;
  logic                  unused_wbits;

  assign unused_wbits = ^wdata[MASK_LSB-1:HI_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_q  <= ADDR_RST;
      sec_q  <= ADDR_RST;
      en_q   <= 1'b0;
      src_q  <= 1'b0;
      mask_q <= '0;
      snap   <= '{pri: ADDR_RST, sec: ADDR_RST, sec_en: 1'b0, sec_src: 1'b0, sec_mask: '0};
    end else begin
      if (we) begin
        case (cfg_sel_e'(sel))
          SEL_PRI_LO: pri_q[REG_W-1:0]      <= wdata;
          SEL_PRI_HI: pri_q[ADDR_W-1:REG_W] <= wdata[HI_W-1:0];
          SEL_SEC_LO: sec_q[REG_W-1:0]      <= wdata;
          SEL_SEC_HI: begin
            sec_q[ADDR_W-1:REG_W] <= wdata[HI_W-1:0];
            en_q   <= wdata[EN_BIT];
            src_q  <= wdata[SRC_BIT];
            mask_q <= wdata[MASK_LSB +: ADDR_BYTES];
          end
          default: ;
        endcase
      end
      // Snapshot samples the registers before any same-edge write lands.
      if (snap_load)
        snap <= '{pri: pri_q, sec: sec_q, sec_en: en_q, sec_src: src_q, sec_mask: mask_q};
    end
  end
endmodule

// File: rtl/mpf_frame_capture.sv
module mpf_frame_capture
  import mpf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [BYTE_W-1:0] rx_data,
  output logic [ADDR_W-1:0] da,
  output logic [ADDR_W-1:0] sa,
  output logic              hdr_done,
  output logic              short_end
);
  localparam logic [CNT_W-1:0] HDR_CNT = CNT_W'(HDR_BYTES);
  localparam int               STORE_N = HDR_BYTES - 1;

  logic [BYTE_W-1:0] hdr_q [STORE_N];
  logic [CNT_W-1:0]  cnt_q, cnt_nxt, wr_idx;
  logic              open_q, accept;

  assign accept    = rx_valid && (rx_sof || (open_q && cnt_q < HDR_CNT));
  assign cnt_nxt   = rx_sof ? CNT_W'(1) : cnt_q + CNT_W'(1);
  assign wr_idx    = rx_sof ? '0 : cnt_q;
  assign hdr_done  = accept && (cnt_nxt == HDR_CNT);
  assign short_end = accept && rx_eof && (cnt_nxt < HDR_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
      for (int i = 0; i < STORE_N; i++) hdr_q[i] <= '0;
    end else begin
      if (accept) cnt_q <= cnt_nxt;
      if (rx_valid) begin
        if (rx_eof)      open_q <= 1'b0;
        else if (rx_sof) open_q <= 1'b1;
      end
      for (int i = 0; i < STORE_N; i++)
        if (accept && wr_idx == CNT_W'(i)) hdr_q[i] <= rx_data;
    end
  end

  // First wire byte lands in the least significant address byte.
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_da
    assign da[k*BYTE_W +: BYTE_W] = hdr_q[k];
  end
  for (genvar k = 0; k < ADDR_BYTES - 1; k++) begin : g_sa
    assign sa[k*BYTE_W +: BYTE_W] = hdr_q[ADDR_BYTES + k];
  end
  assign sa[ADDR_W-1 -: BYTE_W] = rx_data;
endmodule

// File: rtl/mac_addr_filter.sv
module mac_addr_filter
  import mpf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_data,
  output logic        res_valid,
  output logic        res_pri_hit,
  output logic        res_sec_hit,
  output logic        res_pass
);
  filt_cfg_t         cfg_snap;
  logic [ADDR_W-1:0] cap_da, cap_sa, sec_field;
  logic              snap_load, hdr_done, short_end;
  logic              pri_match, sec_match;

  assign snap_load = rx_valid && rx_sof;

  mpf_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .snap_load(snap_load), .snap(cfg_snap)
  );

  mpf_frame_capture u_cap (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .da(cap_da), .sa(cap_sa),
    .hdr_done(hdr_done), .short_end(short_end)
  );

  assign sec_field = cfg_snap.sec_src ? cap_sa : cap_da;
  assign pri_match = addr_hit(cfg_snap.pri, cap_da, '0);
  assign sec_match = cfg_snap.sec_en && addr_hit(cfg_snap.sec, sec_field, cfg_snap.sec_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_pri_hit <= 1'b0;
      res_sec_hit <= 1'b0;
      res_pass    <= 1'b0;
    end else begin
      res_valid   <= hdr_done || short_end;
      res_pri_hit <= hdr_done && pri_match;
      res_sec_hit <= hdr_done && sec_match;
      res_pass    <= hdr_done && (pri_match || sec_match);
    end
  end
endmodule

// File: rtl/mpf_checker.sv
module mpf_checker
  import mpf_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      hdr_done,
  input logic      short_end,
  input logic      snap_load,
  input filt_cfg_t snap,
  input logic      res_valid,
  input logic      res_pri_hit,
  input logic      res_sec_hit,
  input logic      res_pass
);
  p_quiet_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !(res_pri_hit || res_sec_hit || res_pass));

  p_strobe_after_header_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |=> res_valid);

  p_no_spurious_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_done || short_end) |=> !res_valid);

  p_short_rejects_r10: assert property (@(posedge clk) disable iff (!rst_n)
    short_end |=> (res_valid && !res_pass && !res_pri_hit && !res_sec_hit));

  p_sec_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !snap.sec_en) |-> !res_sec_hit);

  p_pass_union_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_pass == (res_pri_hit || res_sec_hit)));

  p_snap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_load |=> $stable(snap));
endmodule

bind mac_addr_filter mpf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_done(hdr_done), .short_end(short_end),
  .snap_load(snap_load), .snap(cfg_snap), .res_valid(res_valid),
  .res_pri_hit(res_pri_hit), .res_sec_hit(res_sec_hit), .res_pass(res_pass)
);

// File: tb/mac_addr_filter_bench.sv
module mac_addr_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        res_valid, res_pri_hit, res_sec_hit, res_pass;

  int checks = 0, errors = 0, cyc = 0;
  int strobes = 0, strobe_cyc = 0, b11_cyc = 0;
  logic [2:0] last_flags = '0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  mac_addr_filter u_mac_addr_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .res_valid(res_valid),
    .res_pri_hit(res_pri_hit), .res_sec_hit(res_sec_hit), .res_pass(res_pass)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (res_valid) begin
      strobes    <= strobes + 1;
      strobe_cyc <= cyc;
      last_flags <= {res_pri_hit, res_sec_hit, res_pass};
    end
  end

  typedef struct packed {
    logic [47:0] pri;
    logic [31:0] shi;
    logic [31:0] slo;
    logic [47:0] da;
    logic [47:0] sa;
    logic [2:0]  exp;   // {primary hit, secondary hit, pass}
  } vec_t;

  localparam logic [47:0] P = 48'h0A0B0C0D0E0F;
  localparam logic [47:0] S = 48'h112233445566;
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{P, 32'h00001122, 32'h33445566, P,                 48'h0, 3'b101},
    '{P, 32'h00001122, 32'h33445566, 48'h0A0B0C0D0E0E,  48'h0, 3'b000},
    '{P, 32'h80001122, 32'h33445566, S,                 48'h0, 3'b011},
    '{P, 32'hC0001122, 32'h33445566, S,                 48'h0, 3'b000},
    '{P, 32'hC0001122, 32'h33445566, P,                 S,     3'b111},
    '{P, 32'h00001122, 32'h33445566, S,                 48'h0, 3'b000},
    '{P, 32'h81001122, 32'h33445566, 48'h1122334455AA,  48'h0, 3'b011},
    '{P, 32'hA0001122, 32'h33445566, 48'hFF2233445566,  48'h0, 3'b011},
    '{P, 32'h81001122, 32'h33445566, 48'hFF22334455AA,  48'h0, 3'b000},
    '{P, 32'hBF001122, 32'h33445566, 48'h0,             48'h0, 3'b011},
    '{P, 32'h00001122, 32'h33445566, 48'h0F0E0D0C0B0A,  48'h0, 3'b000},
    '{P, 32'h80001122, 32'h33445566, P,                 S,     3'b101}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input logic [47:0] pri, input logic [31:0] shi, input logic [31:0] slo);
    write_reg(2'd0, pri[31:0]);
    write_reg(2'd1, {16'h0, pri[47:32]});
    write_reg(2'd2, slo);
    write_reg(2'd3, shi);
  endtask

  // Sends len bytes; optional configuration write alongside byte wr_at.
  task automatic send_frame(input logic [47:0] da, input logic [47:0] sa, input int len,
                            input int wr_at, input logic [1:0] wsel, input logic [31:0] wdat);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = (i == len - 1);
      rx_data  = (i < 6) ? da[8*i +: 8] : (i < 12) ? sa[8*(i-6) +: 8] : 8'hA5;
      if (i == 11) b11_cyc = cyc;
      cfg_we = (i == wr_at); cfg_sel = wsel; cfg_wdata = wdat;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic frame_check(input string tag, input logic [47:0] da, input logic [47:0] sa,
                             input int len, input logic [2:0] exp);
    int s0;
    s0 = strobes;
    send_frame(da, sa, len, -1, 2'd0, 32'h0);
    chk({tag, " strobe count"}, 64'(strobes - s0), 64'd1);
    chk({tag, " flags"}, 64'(last_flags), 64'(exp));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    chk("R12 reset strobe low", 64'(res_valid), 64'd0);
    chk("R12 reset flags low", 64'({res_pri_hit, res_sec_hit, res_pass}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset addresses all ones, secondary disabled
    frame_check("R1 reset primary ones", 48'hFFFFFFFFFFFF, 48'h0, 12, 3'b101);
    write_reg(2'd3, 32'h8000FFFF);
    frame_check("R1 reset secondary low ones", 48'hFFFFFFFFFFFF, 48'h0, 12, 3'b111);

    // Table walk: R3 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      prog(VECS[v].pri, VECS[v].shi, VECS[v].slo);
      frame_check($sformatf("R3/R5/R6/R7/R8/R9 vector %0d", v), VECS[v].da, VECS[v].sa, 12, VECS[v].exp);
    end

    // R2: upper bits of primary high write ignored
    prog(P, 32'h00001122, 32'h33445566);
    write_reg(2'd1, 32'hFFFF0A0B);
    frame_check("R2 primary high upper bits ignored", P, 48'h0, 12, 3'b101);

    // R4: timing and trailing bytes
    s0 = strobes;
    send_frame(P, S, 16, -1, 2'd0, 32'h0);
    chk("R4 single strobe on long frame", 64'(strobes - s0), 64'd1);
    chk("R4 strobe cycle after 12th byte", 64'(strobe_cyc), 64'(b11_cyc + 1));
    chk("R4 long frame flags", 64'(last_flags), 64'(3'b101));

    // R10: short frames
    frame_check("R10 five-byte frame", P, 48'h0, 5, 3'b000);
    frame_check("R10 eleven-byte frame", P, S, 11, 3'b000);
    frame_check("R10 end on 12th byte", P, S, 12, 3'b101);

    // R11: mid-frame write
    s0 = strobes;
    send_frame(P, 48'h0, 12, 3, 2'd0, 32'h0);
    chk("R11 mid-frame write not applied", 64'(last_flags), 64'(3'b101));
    frame_check("R11 write applied next frame", P, 48'h0, 12, 3'b000);
    send_frame(P, 48'h0, 12, 0, 2'd0, P[31:0]);
    chk("R11 write with start byte not applied", 64'(last_flags), 64'(3'b000));
    frame_check("R11 start-byte write applied next frame", P, 48'h0, 12, 3'b101);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule